// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor as a single interrupt output. It latches incoming requests, filters them through a software-written mask, picks the most urgent one under a fixed ordering and allows a more urgent request to pre-empt one already being handled. The processor answers with two acknowledge pulses. The first moves the winning request into service. During the second, the block drives an 8-bit type code on its data bus.

Software sets the block up over a small register interface. That interface has an 8-bit data bus, an active-low chip select, active-low read and write strobes and one address line. Configuration is an ordered run of two to four initialization words. Flag bits in the first and last words select the trigger type, whether a cascade word and a final word follow, the end-of-service style and the nesting rule. Once configured, the block accepts mask writes and end-of-interrupt commands. All interface inputs are sampled on the block clock. A write or a first acknowledge takes effect on the first clock at which its strobe is seen low.

Top module: `prio_intc`

## Requirements
- R1: After reset, int_o and data_oe_o are low, the mask reads back as 0x00 and the block counts as not initialized.
- R2: A write with addr_i=0 and data bit 4 set is the first initialization word. It restarts the sequence and clears the mask, the in-service bits and the request bits. int_o stays low until the sequence completes.
- R3: In the first word, bit 0=1 means a fourth word follows and bit 1=1 means single operation with no third word. Bit 3=1 selects level-triggered requests and bit 3=0 selects edge-triggered requests.
- R4: The next write with addr_i=1 is the second word. Its bits 7..3 become bits 7..3 of every type code, and bits 2..0 of the type code are the number of the request line being served.
- R5: A third word (addr_i=1) is consumed and discarded only when bit 1 of the first word was 0. Without a fourth word, the block runs with normal end-of-interrupt and plain nesting.
- R6: In the fourth word (addr_i=1), bit 1=1 enables automatic end-of-interrupt and bit 4=1 enables special fully nested mode. In that mode, a request at the same level as the top in-service level may also interrupt.
- R7: After initialization, a write with addr_i=1 loads the mask, and a mask bit of 1 blocks the request line of the same number. A read with addr_i=1 drives the mask on data_o with data_oe_o high.
- R8: Line 0 has the highest priority and line 7 the lowest. int_o goes high when the best unmasked pending request has a lower number than every in-service level.
- R9: On the first falling edge of inta_ni, the winning request's in-service bit is set and its request bit is cleared. While inta_ni is low during the second pulse, data_o carries the type code and data_oe_o is high. If nothing was winning at the first pulse, the type code names line 7 and no in-service bit is set.
- R10: A write of 0x20 with addr_i=0 clears the highest-priority in-service bit. Other addr_i=0 writes with bit 4 clear change nothing.
- R11: With automatic end-of-interrupt, the served in-service bit clears when inta_ni rises at the end of the second pulse.
- R12: Request lines pass a two-stage synchronizer. In edge mode, a rising edge latches a request bit that stays set after the line falls, until it is acknowledged or flushed. In level mode, the request bit follows the synchronized line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 1 | Register address line |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or type code |
| data_oe_o | output | 1 | High while the block drives data_o |
| inta_ni | input | 1 | Interrupt acknowledge, active low |
| irq_i | input | 8 | Request lines, line 0 most urgent |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions check several properties on every cycle. int_o is never raised without a completed configuration, and a full mask always keeps it low. An in-service bit appears only while an acknowledge is in progress, and no more than one in-service bit retires per cycle. The driven type code always names a level that is in service, or line 7. The bus drives data only during a read or a vector phase. Only the scenarios can show the rest: the exact type code values, the nesting and same-level rules under each mode, the ignored command values, the word count chosen by the flag bits, and the difference between edge and level behaviour after the line falls.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    CFG_WAIT1, CFG_EXP2, CFG_EXP3, CFG_EXP4, CFG_READY
  } cfg_state_e;

  typedef enum logic [1:0] {
    ACK_IDLE, ACK_WAIT2, ACK_VEC
  } ack_state_e;

  typedef struct packed {
    logic need_last;
    logic single;
    logic level;
    logic auto_eoi;
    logic sfn;
  } pic_mode_t;

  localparam logic [7:0] EOI_CMD = 8'h20;
endpackage

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3,
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] data_i,
  output pic_mode_t         mode_o,
  output logic [BASE_W-1:0] base_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              ready_o,
  output logic              flush_o,
  output logic              eoi_o
);
  cfg_state_e        st_q;
  pic_mode_t         mode_q;
  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] mask_q;

  logic first_w, cmd_w, hi_w;
  assign first_w = wr_stb_i & ~addr_i & data_i[4];
  assign cmd_w   = wr_stb_i & ~addr_i & ~data_i[4];
  assign hi_w    = wr_stb_i & addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CFG_WAIT1;
      mode_q <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (first_w) begin
      mode_q.need_last <= data_i[0];
      mode_q.single    <= data_i[1];
      mode_q.level     <= data_i[3];
      mode_q.auto_eoi  <= 1'b0;
      mode_q.sfn       <= 1'b0;
      mask_q           <= '0;
      st_q             <= CFG_EXP2;
    end else if (hi_w) begin
      unique case (st_q)
        CFG_EXP2: begin
          base_q <= data_i[DATA_W-1:LVL_W];
          if (!mode_q.single)       st_q <= CFG_EXP3;
          else if (mode_q.need_last) st_q <= CFG_EXP4;
          else                       st_q <= CFG_READY;
        end
        CFG_EXP3: st_q <= mode_q.need_last ? CFG_EXP4 : CFG_READY;
        CFG_EXP4: begin
          mode_q.auto_eoi <= data_i[1];
          mode_q.sfn      <= data_i[4];
          st_q            <= CFG_READY;
        end
        CFG_READY: mask_q <= data_i;
        default: ;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign base_o  = base_q;
  assign mask_o  = mask_q;
  assign ready_o = (st_q == CFG_READY);
  assign flush_o = first_w;
  assign eoi_o   = cmd_w & (st_q == CFG_READY) & (data_i == EOI_CMD);
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int IRQ_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic             level_i,
  input  logic             flush_i,
  input  logic [IRQ_W-1:0] clr_i,
  output logic [IRQ_W-1:0] irr_o
);
  logic [SYNC_STAGES-1:0][IRQ_W-1:0] stage_q;
  logic [IRQ_W-1:0] prev_q, irr_q, irr_d, line_s;

  assign line_s = stage_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= irq_i;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= line_s;
    end
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    logic rise;
    assign rise     = line_s[b] & ~prev_q[b];
    assign irr_d[b] = level_i ? line_s[b] : ((irr_q[b] & ~clr_i[b]) | rise);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irr_q <= '0;
    else if (flush_i) irr_q <= '0;
    else              irr_q <= irr_d;
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_svc.sv
module pic_svc
  import pic_pkg::*;
#(
  parameter int IRQ_W  = 8,
  parameter int DATA_W = 8,
  localparam int LVL_W  = $clog2(IRQ_W),
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_W-1:0]  irr_i,
  input  logic [IRQ_W-1:0]  mask_i,
  input  logic              ready_i,
  input  logic              sfn_i,
  input  logic              auto_eoi_i,
  input  logic              eoi_i,
  input  logic              flush_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              inta_ni,
  output logic              int_o,
  output logic [IRQ_W-1:0]  clr_o,
  output logic [IRQ_W-1:0]  isr_o,
  output logic              vec_oe_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam logic [LVL_W:0] NONE = (LVL_W+1)'(IRQ_W);

  function automatic logic [LVL_W:0] first_idx(logic [IRQ_W-1:0] v);
    first_idx = NONE;
    for (int i = IRQ_W - 1; i >= 0; i--) if (v[i]) first_idx = (LVL_W+1)'(i);
  endfunction

  ack_state_e       st_q;
  logic [LVL_W-1:0] lvl_q;
  logic             valid_q, int_q, ack_pv_q;
  logic [IRQ_W-1:0] isr_q, pend, set_m, eoi_m, aeoi_m;
  logic [LVL_W:0]   win, top;
  logic             fire, ack_fall, ack_rise;

  assign pend     = irr_i & ~mask_i;
  assign win      = first_idx(pend);
  assign top      = first_idx(isr_q);
  assign fire     = ready_i & (|pend) & (sfn_i ? (win <= top) : (win < top));
  assign ack_fall = ack_pv_q & ~inta_ni;
  assign ack_rise = ~ack_pv_q & inta_ni;

  assign set_m  = (st_q == ACK_IDLE && ack_fall && fire) ?
                  (IRQ_W'(1) << win[LVL_W-1:0]) : '0;
  assign eoi_m  = (eoi_i && top != NONE) ? (IRQ_W'(1) << top[LVL_W-1:0]) : '0;
  assign aeoi_m = (st_q == ACK_VEC && ack_rise && auto_eoi_i && valid_q) ?
                  (IRQ_W'(1) << lvl_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ACK_IDLE;
      lvl_q    <= '0;
      valid_q  <= 1'b0;
      ack_pv_q <= 1'b1;
      isr_q    <= '0;
      int_q    <= 1'b0;
    end else begin
      ack_pv_q <= inta_ni;
      int_q    <= fire;
      isr_q    <= flush_i ? '0 : ((isr_q & ~eoi_m & ~aeoi_m) | set_m);
      if (flush_i) begin
        st_q <= ACK_IDLE;
      end else begin
        unique case (st_q)
          ACK_IDLE: if (ack_fall) begin
            st_q    <= ACK_WAIT2;
            valid_q <= fire;
            lvl_q   <= fire ? win[LVL_W-1:0] : '1;  // nothing winning: last line
          end
          ACK_WAIT2: if (ack_fall) st_q <= ACK_VEC;
          ACK_VEC:   if (ack_rise) st_q <= ACK_IDLE;
          default:   st_q <= ACK_IDLE;
        endcase
      end
    end
  end

  assign int_o    = int_q;
  assign clr_o    = set_m;
  assign isr_o    = isr_q;
  assign vec_oe_o = (st_q == ACK_VEC) & ~inta_ni;
  assign vec_o    = {base_i, lvl_q};
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int IRQ_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W  = $clog2(IRQ_W),
  localparam int BASE_W = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              inta_ni,
  input  logic [IRQ_W-1:0]  irq_i,
  output logic              int_o
);
  logic              wr_pv_q, wr_stb, rd_act;
  pic_mode_t         mode;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] mask, vec;
  logic              ready, flush, eoi, vec_oe;
  logic [IRQ_W-1:0]  irr, clr, isr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_pv_q <= 1'b1;
    else         wr_pv_q <= wr_ni;
  end

  assign wr_stb = ~cs_ni & ~wr_ni & wr_pv_q;
  assign rd_act = ~cs_ni & ~rd_ni & addr_i;

  pic_regif #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regif (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .addr_i, .data_i,
    .mode_o(mode), .base_o(base), .mask_o(mask),
    .ready_o(ready), .flush_o(flush), .eoi_o(eoi)
  );

  pic_req #(.IRQ_W(IRQ_W), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i, .rst_ni, .irq_i, .level_i(mode.level), .flush_i(flush),
    .clr_i(clr), .irr_o(irr)
  );

  pic_svc #(.IRQ_W(IRQ_W), .DATA_W(DATA_W)) u_svc (
    .clk_i, .rst_ni, .irr_i(irr), .mask_i(mask[IRQ_W-1:0]), .ready_i(ready),
    .sfn_i(mode.sfn), .auto_eoi_i(mode.auto_eoi), .eoi_i(eoi), .flush_i(flush),
    .base_i(base), .inta_ni, .int_o, .clr_o(clr), .isr_o(isr),
    .vec_oe_o(vec_oe), .vec_o(vec)
  );

  assign data_oe_o = vec_oe | rd_act;
  assign data_o    = vec_oe ? vec : (rd_act ? mask : '0);
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_o,
  input logic       ready,
  input logic [7:0] mask,
  input logic [7:0] isr,
  input logic       inta_ni,
  input logic       vec_oe,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       cs_ni,
  input logic       rd_ni
);
  // R2
  int_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> $past(ready));

  // R7
  full_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask) == 8'hff) |-> !int_o);

  // R9
  isr_set_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isr & ~$past(isr))) |-> $past(!inta_ni));

  // R10
  one_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(isr) & ~isr) <= 1 || isr == 8'h00);

  // R9
  vec_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe |-> (isr[data_o[2:0]] || data_o[2:0] == 3'd7));

  // R7
  bus_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!inta_ni || (!cs_ni && !rd_ni)));
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk_i, .rst_ni, .int_o, .ready, .mask, .isr, .inta_ni, .vec_oe,
  .data_o, .data_oe_o, .cs_ni, .rd_ni
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, wr_n = 1, rd_n = 1, addr = 0, inta_n = 1;
  logic [7:0] din = 0, irq = 0;
  logic [7:0] dout;
  logic oe, intr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .inta_ni(inta_n), .irq_i(irq), .int_o(intr)
  );

  // behavioural reference model
  logic [7:0] m_s1, m_s2, m_pv, m_irr, m_imr, m_isr;
  int m_st, m_ack, m_alvl, m_base;
  bit m_int, m_need4, m_single, m_level, m_aeoi, m_sfn, m_avalid, m_wrpv, m_iapv;
  logic [7:0] t_pend, t_edge, t_set, t_eoi, t_aeoi;
  int t_w, t_tp;
  bit t_fire, t_wst, t_fe, t_re, t_first;

  function automatic int first8(logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_irr = 0; m_imr = 0; m_isr = 0;
      m_st = 0; m_ack = 0; m_alvl = 0; m_base = 0; m_int = 0;
      m_need4 = 0; m_single = 0; m_level = 0; m_aeoi = 0; m_sfn = 0;
      m_avalid = 0; m_wrpv = 1; m_iapv = 1;
    end else begin
      t_wst   = !cs_n && !wr_n && m_wrpv;
      t_fe    = m_iapv && !inta_n;
      t_re    = !m_iapv && inta_n;
      t_pend  = m_irr & ~m_imr;
      t_w     = first8(t_pend);
      t_tp    = first8(m_isr);
      t_fire  = (m_st == 4) && t_pend != 0 && (m_sfn ? t_w <= t_tp : t_w < t_tp);
      t_edge  = m_s2 & ~m_pv;
      t_first = t_wst && !addr && din[4];
      t_set   = (m_ack == 0 && t_fe && t_fire) ? 8'(1 << t_w) : 8'h00;
      t_eoi   = (t_wst && !addr && !din[4] && din == 8'h20 && m_st == 4 && t_tp < 8)
                ? 8'(1 << t_tp) : 8'h00;
      t_aeoi  = (m_ack == 2 && t_re && m_aeoi && m_avalid) ? 8'(1 << m_alvl) : 8'h00;
      m_int = t_fire;
      if (t_first) m_ack = 0;
      else if (m_ack == 0 && t_fe) begin
        m_ack = 1; m_avalid = t_fire; m_alvl = t_fire ? t_w : 7;
      end else if (m_ack == 1 && t_fe) m_ack = 2;
      else if (m_ack == 2 && t_re) m_ack = 0;
      m_isr = t_first ? 8'h00 : ((m_isr & ~t_eoi & ~t_aeoi) | t_set);
      m_irr = t_first ? 8'h00 : (m_level ? m_s2 : ((m_irr & ~t_set) | t_edge));
      m_pv = m_s2; m_s2 = m_s1; m_s1 = irq;
      if (t_first) begin
        m_need4 = din[0]; m_single = din[1]; m_level = din[3];
        m_aeoi = 0; m_sfn = 0; m_imr = 0; m_st = 1;
      end else if (t_wst && addr) begin
        case (m_st)
          1: begin m_base = din >> 3; m_st = !m_single ? 2 : (m_need4 ? 3 : 4); end
          2: m_st = m_need4 ? 3 : 4;
          3: begin m_aeoi = din[1]; m_sfn = din[4]; m_st = 4; end
          4: m_imr = din;
          default: ;
        endcase
      end
      m_wrpv = wr_n; m_iapv = inta_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_oe;
      exp_oe = (m_ack == 2 && !inta_n) || (!cs_n && !rd_n && addr);
      chk("R8 int_o vs model", intr, m_int);
      chk("R9 data_oe_o vs model", oe, exp_oe);
      if (exp_oe)
        chk("R9 data_o vs model", dout,
            (m_ack == 2 && !inta_n) ? ((m_base << 3) | m_alvl) : m_imr);
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic bus_wr(bit a, logic [7:0] d);
    @(posedge clk); #3 cs_n = 0; wr_n = 0; addr = a; din = d;
    repeat (2) @(posedge clk);
    #3 wr_n = 1; cs_n = 1;
    idle(1);
  endtask

  task automatic bus_rd(bit a, output logic [7:0] d, output logic e);
    @(posedge clk); #3 cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk); d = dout; e = oe;
    @(posedge clk); #3 rd_n = 1; cs_n = 1;
  endtask

  task automatic ack(output logic [7:0] v);
    @(posedge clk); #3 inta_n = 0;
    repeat (3) @(posedge clk);
    #3 inta_n = 1;
    repeat (2) @(posedge clk);
    #3 inta_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); v = dout;
    chk("R9 oe during vector", oe, 1);
    @(posedge clk); #3 inta_n = 1;
    idle(3);
  endtask

  task automatic int_is(string tag, bit e);
    idle(6);
    @(negedge clk);
    chk(tag, intr, e);
    idle(1);
  endtask

  logic [7:0] v, rdv;
  logic rde;

  initial begin
    repeat (3) @(posedge clk);
    #3;
    @(negedge clk);
    chk("R1 int_o at reset", intr, 0);
    chk("R1 data_oe_o at reset", oe, 0);
    rst_n = 1;
    idle(2);
    bus_rd(1, rdv, rde);
    chk("R1 mask after reset", rdv, 8'h00);
    chk("R7 read drives bus", rde, 1);
    irq[0] = 1;
    int_is("R2 no int before init", 0);
    irq[0] = 0;
    idle(3);

    // edge, single, fourth word, normal end
    bus_wr(0, 8'h13); bus_wr(1, 8'h08); bus_wr(1, 8'h01);
    bus_wr(1, 8'h5a);
    bus_rd(1, rdv, rde);
    chk("R7 mask readback", rdv, 8'h5a);
    bus_wr(1, 8'h00);
    irq[3] = 1;
    int_is("R8 int for line 3", 1);
    ack(v);
    chk("R4 type code line 3", v, 8'h0b);
    int_is("R9 request moved to service", 0);
    irq[3] = 0; idle(3); irq[3] = 1;
    int_is("R8 same level blocked", 0);
    irq[3] = 0;
    irq[5] = 1;
    int_is("R8 lower level blocked", 0);
    irq[1] = 1;
    int_is("R8 higher level nests", 1);
    ack(v);
    chk("R4 type code line 1", v, 8'h09);
    bus_wr(0, 8'h20);
    int_is("R10 eoi clears only line 1", 0);
    bus_wr(0, 8'h20);
    int_is("R12 edge held for line 3", 1);
    ack(v);
    chk("R12 held line 3 served", v, 8'h0b);
    bus_wr(0, 8'h00);
    int_is("R10 other command ignored", 0);
    bus_wr(0, 8'h20);
    int_is("R10 eoi releases line 5", 1);
    ack(v);
    chk("R8 type code line 5", v, 8'h0d);
    bus_wr(0, 8'h20);
    int_is("R10 nothing left", 0);
    irq = 0; idle(3);

    bus_wr(1, 8'h04);
    bus_rd(1, rdv, rde);
    chk("R7 mask 0x04", rdv, 8'h04);
    irq[2] = 1; idle(3); irq[2] = 0;
    int_is("R7 masked line quiet", 0);
    bus_wr(1, 8'h00);
    int_is("R12 edge latched after line fell", 1);
    ack(v);
    chk("R12 type code line 2", v, 8'h0a);
    bus_wr(0, 8'h20);

    ack(v);
    chk("R9 spurious type code", v, 8'h0f);
    irq[7] = 1;
    int_is("R9 spurious set no service bit", 1);
    ack(v);
    chk("R9 line 7 type code", v, 8'h0f);
    bus_wr(0, 8'h20);
    irq = 0; idle(3);

    // special fully nested
    bus_wr(1, 8'h80);
    bus_wr(0, 8'h13);
    bus_rd(1, rdv, rde);
    chk("R2 first word clears mask", rdv, 8'h00);
    irq[4] = 1;
    int_is("R2 int held low mid sequence", 0);
    bus_wr(1, 8'h10); bus_wr(1, 8'h10);
    int_is("R2 int after sequence", 1);
    ack(v);
    chk("R4 base 0x10 line 4", v, 8'h14);
    irq[4] = 0; idle(3); irq[4] = 1;
    int_is("R6 same level re-enters", 1);
    ack(v);
    chk("R6 nested same level", v, 8'h14);
    bus_wr(0, 8'h20); bus_wr(0, 8'h20);
    irq = 0; idle(3);

    // level, cascaded, auto end
    bus_wr(0, 8'h19); bus_wr(1, 8'ha0); bus_wr(1, 8'h00); bus_wr(1, 8'h02);
    bus_wr(1, 8'h33);
    bus_rd(1, rdv, rde);
    chk("R5 third word consumed", rdv, 8'h33);
    bus_wr(1, 8'h00);
    irq[0] = 1;
    int_is("R3 level request", 1);
    ack(v);
    chk("R4 base 0xa0 line 0", v, 8'ha0);
    int_is("R11 auto end, level still high", 1);
    irq[0] = 0;
    int_is("R12 level request follows line", 0);
    irq[1] = 1;
    int_is("R3 level line 1", 1);
    ack(v);
    irq[1] = 0;
    chk("R11 type code line 1", v, 8'ha1);
    irq[3] = 1;
    int_is("R11 service bit retired", 1);
    ack(v);
    chk("R11 type code line 3", v, 8'ha3);
    irq = 0; idle(3);

    // no fourth word
    bus_wr(0, 8'h12); bus_wr(1, 8'h30);
    bus_wr(1, 8'h01);
    bus_rd(1, rdv, rde);
    chk("R5 ready after two words", rdv, 8'h01);
    irq[0] = 1;
    int_is("R7 masked line 0", 0);
    irq[6] = 1;
    int_is("R3 edge line 6", 1);
    ack(v);
    chk("R4 base 0x30 line 6", v, 8'h36);
    irq[7] = 1;
    int_is("R5 normal end by default", 0);
    bus_wr(0, 8'h20);
    int_is("R10 eoi releases line 7", 1);
    ack(v);
    chk("R8 type code line 7", v, 8'h37);
    bus_wr(0, 8'h20);
    irq = 0;
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule